// File: doc/BRIEF.md
# Multiplexed Interrupt Priority Vector Controller

This block merges a set of peripheral event sources onto one shared interrupt line. Each source has a sticky pending bit, set by a one-cycle event pulse, and a mask bit that enables it. The pending bits that are also enabled are called the active set. A fixed table gives each source its own nonzero priority code, and a priority encoder picks the active source with the lowest code. That code sits in a vector register that software can read.

A bus read of the vector register returns the registered code and acknowledges that source by clearing its pending bit. The vector then reads zero for one cycle. After that it reloads with the code of the next winner. Software therefore drains all enabled sources by reading the vector until it returns zero, leaving one idle cycle between reads.

A separate shared interrupt flag is raised whenever a source joins the active set. It stays raised until the CPU signals that it has vectored to the shared handler.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every pending and mask bit is zero, the vector reads 00H and `irq` is low.
- R2: An `evt[i]` pulse sets pending bit i on the next clock edge. The bit stays set until software clears it by a write or by an acknowledging vector read. Unmasked sources also stay pending.
- R3: The pending bits are read and written through two addresses. Address 0 maps bits 7:0 to sources 7:0. Address 1 maps bits 3:0 to sources 11:8, and its bits 7:4 always read zero and ignore writes. Writing a 1 to a pending bit clears it, and writing a 0 leaves it unchanged.
- R4: The mask register uses the same layout at address 2 (sources 7:0) and address 3 (sources 11:8 in bits 3:0, with bits 7:4 read as zero). It is plain read/write, and a 1 enables the source.
- R5: The vector register is at address 4. One cycle after the active set changes, it holds the lowest code among the active sources, or 00H if none are active. The default code table for sources 0 to 11 is 3,4,1,2,7,8,5,6,11,12,9,10. Writes to address 4 have no effect.
- R6: A read at address 4 returns the vector as registered before the edge and clears the pending bit of the source with that code. In the next cycle the vector reads 00H. One cycle after that, it holds the next winner.
- R7: When an event and a clear (a vector read or a pending write) hit the same bit in the same cycle, the bit stays set. When they hit different bits, both updates take effect.
- R8: `irq` rises on the edge after any source enters the active set. This happens through an event or through a mask write. `irq_ack` clears `irq` on the next edge, even while sources remain active. If a new source enters the active set in the same cycle as `irq_ack`, `irq` stays high.
- R9: A vector read that returns 00H clears nothing, and reads at other addresses have no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | N_SRC | One-cycle event pulses, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect at address 4) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_ack | input | 1 | CPU vectored to the shared interrupt |
| irq | output | 1 | Shared interrupt pending flag |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is an event setting a pending bit and an acknowledging vector read (or a pending write) clearing one. The bench provokes this by raising `evt` in the very cycle that holds the vector read or clear write. It drives the same bit once and a different bit once. It judges the result from the code returned by the following vector reads and from the pending register.

The second pair is the shared flag's clear and set. The bench asserts `irq_ack` in the cycle in which a newly active source raises the flag, and expects `irq` to stay high. It then sends a lone acknowledge and expects `irq` to drop.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N_SRC = 12,
  parameter logic [N_SRC*8-1:0] SRC_CODE =
    {8'd10, 8'd9, 8'd12, 8'd11, 8'd6, 8'd5, 8'd8, 8'd7, 8'd2, 8'd1, 8'd4, 8'd3}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [2:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             irq_ack,
  output logic             irq
);
  localparam int HI_W = N_SRC - 8;
  localparam logic [2:0] A_PLO = 3'd0, A_PHI = 3'd1, A_MLO = 3'd2, A_MHI = 3'd3, A_VEC = 3'd4;

  logic [N_SRC-1:0] pend_q, mask_q, act_prev_q, active, clr_wr, clr_rd;
  logic [7:0]       vec_q, enc;
  logic             irq_q, rise, rd_vec;

  assign active = pend_q & mask_q;
  assign rd_vec = bus_rd && bus_addr == A_VEC;
  assign rise   = |(active & ~act_prev_q);
  assign irq    = irq_q;

  assign clr_wr[7:0]       = (bus_wr && bus_addr == A_PLO) ? bus_wdata : 8'd0;
  assign clr_wr[N_SRC-1:8] = (bus_wr && bus_addr == A_PHI) ? bus_wdata[HI_W-1:0] : '0;

  always_comb begin
    enc = 8'd0;
    for (int i = 0; i < N_SRC; i++)
      if (active[i] && (enc == 8'd0 || SRC_CODE[i*8 +: 8] < enc))
        enc = SRC_CODE[i*8 +: 8];
  end

  always_comb begin
    clr_rd = '0;
    for (int i = 0; i < N_SRC; i++)
      clr_rd[i] = rd_vec && vec_q != 8'd0 && SRC_CODE[i*8 +: 8] == vec_q;
  end

  always_comb begin
    case (bus_addr)
      A_PLO:   bus_rdata = pend_q[7:0];
      A_PHI:   bus_rdata = 8'(pend_q[N_SRC-1:8]);
      A_MLO:   bus_rdata = mask_q[7:0];
      A_MHI:   bus_rdata = 8'(mask_q[N_SRC-1:8]);
      A_VEC:   bus_rdata = vec_q;
      default: bus_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      mask_q     <= '0;
      act_prev_q <= '0;
      vec_q      <= 8'd0;
      irq_q      <= 1'b0;
    end else begin
      pend_q     <= (pend_q & ~clr_wr & ~clr_rd) | evt;
      act_prev_q <= active;
      vec_q      <= rd_vec ? 8'd0 : enc;
      irq_q      <= (irq_q & ~irq_ack) | rise;
      if (bus_wr && bus_addr == A_MLO) mask_q[7:0] <= bus_wdata;
      if (bus_wr && bus_addr == A_MHI) mask_q[N_SRC-1:8] <= bus_wdata[HI_W-1:0];
    end
  end
endmodule

module irq_vector_ctrl_chk #(parameter int N_SRC = 12) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] evt,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [2:0]       bus_addr,
  input logic [7:0]       bus_rdata,
  input logic             irq_ack,
  input logic             irq,
  input logic [N_SRC-1:0] pend_q,
  input logic [N_SRC-1:0] mask_q,
  input logic [7:0]       vec_q,
  input logic             rise
);
  localparam int HI_W = N_SRC - 8;

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd1 || bus_addr == 3'd3) |-> (bus_rdata >> HI_W) == 8'd0); // R3
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> (pend_q & $past(evt)) == $past(evt)); // R7
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0 && !bus_wr && !bus_rd) |=> pend_q == $past(pend_q)); // R2
  AST_VEC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd4) |=> vec_q == 8'd0); // R6
  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & mask_q) == '0) |=> vec_q == 8'd0); // R5
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> irq); // R8
  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !rise) |=> !irq); // R8
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_ack(irq_ack), .irq(irq),
  .pend_q(pend_q), .mask_q(mask_q), .vec_q(vec_q), .rise(rise)
);

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;
  logic        clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, irq_ack = 0;
  logic [11:0] evt = '0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic        irq;
  int          nchk = 0, nerr = 0;
  int          CODES [12] = '{3, 4, 1, 2, 7, 8, 5, 6, 11, 12, 9, 10};
  logic [11:0] mpend, mmask;

  always #4 clk = ~clk;

  irq_vector_ctrl uut (.clk, .rst_n, .evt, .bus_wr, .bus_rd, .bus_addr,
                       .bus_wdata, .bus_rdata, .irq_ack, .irq);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_vec(logic [11:0] a);
    logic [7:0] b = 0;
    for (int i = 0; i < 12; i++)
      if (a[i] && (b == 0 || CODES[i] < b)) b = 8'(CODES[i]);
    return b;
  endfunction

  function automatic int src_of(logic [7:0] c);
    for (int i = 0; i < 12; i++) if (CODES[i] == c) return i;
    return -1;
  endfunction

  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1; #1 d = bus_rdata; @(negedge clk); bus_rd = 0;
  endtask
  task automatic pulse(input logic [11:0] e); evt = e; @(negedge clk); evt = '0; endtask
  task automatic ack; irq_ack = 1; @(negedge clk); irq_ack = 0; endtask
  task automatic rd_pend(output logic [11:0] p);
    logic [7:0] lo, hi;
    rd(3'd0, lo); rd(3'd1, hi);
    chk("R3 reserved pend bits", hi[7:4], 0);
    p = {hi[3:0], lo};
  endtask
  task automatic set_mask(input logic [11:0] m);
    wr(3'd2, m[7:0]); wr(3'd3, {4'hF, m[11:8]});
  endtask

  initial begin
    #(200000 * 8);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] v, d;
    logic [11:0] p, e, m, lfsr;
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    chk("R1 irq", irq, 0);
    for (int a = 0; a < 5; a++) begin rd(3'(a), d); chk("R1 reg", d, 0); end

    // R3 pending layout, reserved bits, write-one-to-clear
    pulse(12'hFFF); idle(1);
    wr(3'd1, 8'hF0); rd_pend(p); chk("R3 reserved write ignored", p, 12'hFFF);
    wr(3'd1, 8'h05); rd_pend(p); chk("R3 w1c high", p, 12'hAFF);
    wr(3'd0, 8'h3C); rd_pend(p); chk("R3 w1c low", p, 12'hAC3);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); rd_pend(p); chk("R3 cleared", p, 0);

    // R4 mask layout
    wr(3'd2, 8'hA5); wr(3'd3, 8'hFF);
    rd(3'd2, d); chk("R4 mask low", d, 8'hA5);
    rd(3'd3, d); chk("R4 mask high", d, 8'h0F);
    set_mask(12'h000); ack; idle(1);

    // R5/R6/R8/R9 single-source sweep
    set_mask(12'hFFF); ack;
    for (int i = 0; i < 12; i++) begin
      pulse(12'(1) << i); idle(1);
      chk("R8 irq set", irq, 1);
      ack; chk("R8 irq ack", irq, 0);
      rd(3'd0, d); rd(3'd2, d);
      rd(3'd4, v); chk("R5 code", v, CODES[i]);
      rd(3'd4, v); chk("R6 zero after read", v, 0);
      idle(1); rd(3'd4, v); chk("R9 empty", v, 0);
      rd_pend(p); chk("R6 cleared", p, 0);
    end
    wr(3'd4, 8'hFF); rd(3'd4, v); chk("R5 vector write ignored", v, 0);

    // R2/R5/R6/R8 patterned drains
    lfsr = 12'hACE;
    for (int k = 0; k < 60; k++) begin
      lfsr = {lfsr[10:0], lfsr[11] ^ lfsr[10] ^ lfsr[9] ^ lfsr[3]}; m = lfsr;
      lfsr = {lfsr[10:0], lfsr[11] ^ lfsr[10] ^ lfsr[9] ^ lfsr[3]}; e = lfsr;
      ack; set_mask(m); pulse(e); idle(1);
      chk("R8 irq pattern", irq, (e & m) != 0);
      mpend = e;
      while (exp_vec(mpend & m) != 0) begin
        rd(3'd4, v); chk("R5 drain order", v, exp_vec(mpend & m));
        if (src_of(v) >= 0) mpend[src_of(v)] = 1'b0;
        idle(1);
      end
      rd(3'd4, v); chk("R6 drained", v, 0);
      rd_pend(p); chk("R2 unmasked stay", p, e & ~m);
      wr(3'd0, 8'hFF); wr(3'd1, 8'h0F);
    end

    // R7 same-cycle set and clear
    set_mask(12'hFFF); ack;
    pulse(12'h005); idle(1);
    bus_addr = 3'd4; bus_rd = 1; evt = 12'h004; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0; evt = 0;
    chk("R7 read value", v, 1);
    idle(1); rd(3'd4, v); chk("R7 same bit kept", v, 1);
    idle(1);
    bus_addr = 3'd4; bus_rd = 1; evt = 12'h010; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0; evt = 0;
    chk("R7 read other", v, 3);
    idle(1); rd(3'd4, v); chk("R7 both apply", v, 7);
    idle(1); rd(3'd4, v); chk("R7 empty", v, 0);
    bus_addr = 3'd0; bus_wr = 1; bus_wdata = 8'h01; evt = 12'h001;
    @(negedge clk); bus_wr = 0; evt = 0;
    rd_pend(p); chk("R7 write clear loses", p, 12'h001);
    wr(3'd0, 8'hFF);

    // R8 ack versus new source
    ack; pulse(12'h002); idle(1); chk("R8 set", irq, 1);
    evt = 12'h008; @(negedge clk); evt = 0;
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk("R8 rise beats ack", irq, 1);
    ack; chk("R8 ack with active", irq, 0);
    rd_pend(p); chk("R8 pend kept", p, 12'h00A);
    set_mask(12'h000); idle(1); chk("R8 no rise on mask off", irq, 0);
    set_mask(12'hFFF); idle(1); chk("R8 rise on mask write", irq, 1);
    wr(3'd0, 8'hFF); idle(1);
    rd(3'd4, v); chk("R9 final", v, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule